// File: doc/BRIEF.md
# Virtual Address Translator

This block turns a 32-bit virtual address into a physical address for either an instruction fetch or a data access. Two fixed kernel windows are passed straight through with their three top bits cleared. Every other address is mapped through a paired-page translation array that sits outside this block. The translator drives the page number to look up and the address-space identifier on `lk_vpn` and `lk_asid`. The array answers combinationally in the same cycle with its hit flag, its page-size shift and the frame, valid and dirty data for both halves of the matching pair.

One cycle after a request the translator pulses `rsp_done`. With it come the physical address, an uncacheable flag and a fault code. When the fault is a translation fault, it also gives the values an exception handler loads into its registers: the identifier, the page pair number, the two low page bits, the faulting address and the context page number. Any address-error fault reports the faulting address.

Top module: `va_translator`

## Requirements
- R1: `rsp_done` is high in exactly the cycle after a cycle with `req_valid` high. Without a request, every result output keeps its previous value.
- R2: An address with bits [31:30] equal to 2'b10 bypasses translation. Its result is `rsp_pa` equal to the address with bits [31:29] cleared, whatever the TLB inputs are. This holds unless R3 applies.
- R3: In the cached kernel window (bits [31:29] = 3'b100), a request with `req_kernel` low or `req_misalign` high gives fault code 1 (address error). The uncached window (3'b101) has neither check.
- R4: `lk_vpn` equals `req_va[31:11]`, with its two low bits forced to zero unless `small_pages` is high.
- R5: A mapped request with `req_misalign` high gives fault code 1, whatever the TLB result is.
- R6: A mapped request with `tlb_hit` low gives fault code 2 for a fetch (`req_data` low) and code 3 for a data access.
- R7: On a hit, bit `tlb_page_sh` of the address picks the odd half (1) or the even half (0). If the picked half's valid bit is clear, the fault code is 4 for a fetch and 5 for a data access.
- R8: A data store (`req_data` and `req_store` high) to a valid half whose dirty bit is clear gives fault code 6. Loads and fetches ignore the dirty bit.
- R9: A mapped request that does not fault gives `rsp_pa` = (({pfn, 12'b0}) with its low `tlb_page_sh` bits cleared) OR (address bits below `tlb_page_sh`).
- R10: Translation faults (codes 2 to 6) report `flt_asid` = request identifier, `flt_vpn2` = `flt_ctx_vpn2` = lookup page number >> 2, and `flt_vpn2x` = lookup page number [1:0]. Every fault reports `flt_badva` = the address.
- R11: `rsp_uncached` is high exactly when there is no fault and address bits 31 and 29 are both set.
- R12: On any fault, `rsp_pa` is zero. On an address error, every fault field except `flt_badva` is zero. Without a fault, all fault fields are zero.
- R13: During reset, `rsp_done`, `rsp_fault`, `rsp_pa`, `rsp_uncached` and all fault fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_va | input | 32 | Virtual address |
| req_asid | input | ASID_W | Address-space identifier |
| req_kernel | input | 1 | Requester is in kernel mode |
| req_misalign | input | 1 | Access is misaligned |
| req_data | input | 1 | 1 = data access, 0 = fetch |
| req_store | input | 1 | Data access is a store |
| small_pages | input | 1 | 1 KB page granularity enabled |
| lk_vpn | output | 21 | Page number presented to the TLB |
| lk_asid | output | ASID_W | Identifier presented to the TLB |
| tlb_hit | input | 1 | TLB found a matching entry |
| tlb_page_sh | input | SHIFT_W | Page-size shift of the hit entry |
| tlb_pfn_even | input | PFN_W | Even-half frame number |
| tlb_pfn_odd | input | PFN_W | Odd-half frame number |
| tlb_valid_even | input | 1 | Even-half valid |
| tlb_valid_odd | input | 1 | Odd-half valid |
| tlb_dirty_even | input | 1 | Even-half writable |
| tlb_dirty_odd | input | 1 | Odd-half writable |
| rsp_done | output | 1 | Result strobe |
| rsp_pa | output | 32 | Physical address |
| rsp_uncached | output | 1 | Uncacheable region |
| rsp_fault | output | 3 | Fault code (0 none) |
| flt_asid | output | ASID_W | Faulting identifier |
| flt_vpn2 | output | 19 | Page pair number |
| flt_vpn2x | output | 2 | Low page bits |
| flt_badva | output | 32 | Faulting address |
| flt_ctx_vpn2 | output | 19 | Context page number |

## Verification
The assertions take three things for granted. The TLB answer is stable and valid in the cycle the request is presented. `tlb_page_sh` lies between 10 and 28, so the odd-select bit and the offset mask stay inside the address. `req_valid` stays low until the synchronized reset has been released. The stimulus only ever draws page shifts from that range. It waits out the reset synchronizer before issuing requests. It drives every TLB input together with its request on the same falling edge. Directed cases cover each window and fault code, and random cases mix every input across many requests.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  localparam int VA_W    = 32;
  localparam int PAGE_SH = 11;
  localparam int VPN_W   = VA_W - PAGE_SH;
  localparam int VPN2_W  = VPN_W - 2;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_ADDR    = 3'd1,
    FLT_IREFILL = 3'd2,
    FLT_DREFILL = 3'd3,
    FLT_IINVAL  = 3'd4,
    FLT_DINVAL  = 3'd5,
    FLT_MOD     = 3'd6
  } fault_e;
endpackage

// File: rtl/xlt_rst_sync.sv
module xlt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/xlt_seg_decode.sv
module xlt_seg_decode (
  input  logic [2:0] va_top,
  output logic       unmapped,
  output logic       cached_kwin,
  output logic       uncache_rgn
);
  always_comb begin
    unmapped    = (va_top[2:1] == 2'b10);
    cached_kwin = (va_top == 3'b100);
    uncache_rgn = va_top[2] & va_top[0];
  end
endmodule

// File: rtl/xlt_page_compose.sv
module xlt_page_compose #(
  parameter int PFN_W    = 20,
  parameter int FRAME_SH = 12,
  parameter int SHIFT_W  = 5
) (
  input  logic [31:0]        va,
  input  logic [SHIFT_W-1:0] page_sh,
  input  logic [PFN_W-1:0]   pfn_even,
  input  logic [PFN_W-1:0]   pfn_odd,
  input  logic               v_even,
  input  logic               v_odd,
  input  logic               d_even,
  input  logic               d_odd,
  output logic               sel_valid,
  output logic               sel_dirty,
  output logic [31:0]        pa_mapped
);
  logic             odd_half;
  logic [PFN_W-1:0] pfn_sel;
  logic [31:0]      off_mask;
  logic [31:0]      frame_base;

  always_comb begin
    odd_half   = va[page_sh];
    pfn_sel    = odd_half ? pfn_odd : pfn_even;
    sel_valid  = odd_half ? v_odd : v_even;
    sel_dirty  = odd_half ? d_odd : d_even;
    off_mask   = (32'h1 << page_sh) - 32'h1;
    frame_base = 32'(pfn_sel) << FRAME_SH;
    pa_mapped  = (frame_base & ~off_mask) | (va & off_mask);
  end
endmodule

// File: rtl/xlt_fault_pick.sv
module xlt_fault_pick
  import xlt_pkg::*;
(
  input  logic   unmapped,
  input  logic   cached_kwin,
  input  logic   kernel,
  input  logic   misalign,
  input  logic   is_data,
  input  logic   is_store,
  input  logic   hit,
  input  logic   sel_valid,
  input  logic   sel_dirty,
  output fault_e fault
);
  always_comb begin
    fault = FLT_NONE;
    if (unmapped) begin
      if (cached_kwin && (!kernel || misalign)) fault = FLT_ADDR;
    end else if (misalign) begin
      fault = FLT_ADDR;
    end else if (!hit) begin
      fault = is_data ? FLT_DREFILL : FLT_IREFILL;
    end else if (!sel_valid) begin
      fault = is_data ? FLT_DINVAL : FLT_IINVAL;
    end else if (is_data && is_store && !sel_dirty) begin
      fault = FLT_MOD;
    end
  end
endmodule

// File: rtl/va_translator.sv
module va_translator
  import xlt_pkg::*;
#(
  parameter int ASID_W   = 8,
  parameter int PFN_W    = 20,
  parameter int FRAME_SH = 12,
  parameter int SHIFT_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [31:0]        req_va,
  input  logic [ASID_W-1:0]  req_asid,
  input  logic               req_kernel,
  input  logic               req_misalign,
  input  logic               req_data,
  input  logic               req_store,
  input  logic               small_pages,
  output logic [20:0]        lk_vpn,
  output logic [ASID_W-1:0]  lk_asid,
  input  logic               tlb_hit,
  input  logic [SHIFT_W-1:0] tlb_page_sh,
  input  logic [PFN_W-1:0]   tlb_pfn_even,
  input  logic [PFN_W-1:0]   tlb_pfn_odd,
  input  logic               tlb_valid_even,
  input  logic               tlb_valid_odd,
  input  logic               tlb_dirty_even,
  input  logic               tlb_dirty_odd,
  output logic               rsp_done,
  output logic [31:0]        rsp_pa,
  output logic               rsp_uncached,
  output logic [2:0]         rsp_fault,
  output logic [ASID_W-1:0]  flt_asid,
  output logic [18:0]        flt_vpn2,
  output logic [1:0]         flt_vpn2x,
  output logic [31:0]        flt_badva,
  output logic [18:0]        flt_ctx_vpn2
);
  localparam logic [28:0] KWIN_OFS_ONES = '1;

  logic rst_q_n;

  xlt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  // lookup page number
  logic [VPN_W-1:0] vpn_raw, vpn_lk;

  always_comb begin
    vpn_raw = req_va[31:PAGE_SH];
    vpn_lk  = small_pages ? vpn_raw : {vpn_raw[VPN_W-1:2], 2'b00};
  end

  assign lk_vpn  = vpn_lk;
  assign lk_asid = req_asid;

  logic is_unmapped, is_cached_kwin, is_uc_rgn;

  xlt_seg_decode u_seg (
    .va_top      (req_va[31:29]),
    .unmapped    (is_unmapped),
    .cached_kwin (is_cached_kwin),
    .uncache_rgn (is_uc_rgn)
  );

  logic        half_valid, half_dirty;
  logic [31:0] pa_map;

  xlt_page_compose #(
    .PFN_W    (PFN_W),
    .FRAME_SH (FRAME_SH),
    .SHIFT_W  (SHIFT_W)
  ) u_page (
    .va        (req_va),
    .page_sh   (tlb_page_sh),
    .pfn_even  (tlb_pfn_even),
    .pfn_odd   (tlb_pfn_odd),
    .v_even    (tlb_valid_even),
    .v_odd     (tlb_valid_odd),
    .d_even    (tlb_dirty_even),
    .d_odd     (tlb_dirty_odd),
    .sel_valid (half_valid),
    .sel_dirty (half_dirty),
    .pa_mapped (pa_map)
  );

  fault_e fault_d;

  xlt_fault_pick u_fault (
    .unmapped    (is_unmapped),
    .cached_kwin (is_cached_kwin),
    .kernel      (req_kernel),
    .misalign    (req_misalign),
    .is_data     (req_data),
    .is_store    (req_store),
    .hit         (tlb_hit),
    .sel_valid   (half_valid),
    .sel_dirty   (half_dirty),
    .fault       (fault_d)
  );

  // next-state
  logic              tlb_flt;
  logic [31:0]       pa_d, badva_d;
  logic              uc_d;
  logic [ASID_W-1:0] asid_d;
  logic [18:0]       vpn2_d;
  logic [1:0]        vpn2x_d;

  always_comb begin
    tlb_flt = (fault_d != FLT_NONE) && (fault_d != FLT_ADDR);
    if (fault_d != FLT_NONE) pa_d = '0;
    else if (is_unmapped)    pa_d = {3'b000, req_va[28:0] & KWIN_OFS_ONES};
    else                     pa_d = pa_map;
    uc_d    = (fault_d == FLT_NONE) && is_uc_rgn;
    badva_d = (fault_d != FLT_NONE) ? req_va : '0;
    asid_d  = tlb_flt ? req_asid : '0;
    vpn2_d  = tlb_flt ? vpn_lk[VPN_W-1:2] : '0;
    vpn2x_d = tlb_flt ? vpn_lk[1:0] : '0;
  end

  // registers
  logic              done_q, uc_q;
  fault_e            fault_q;
  logic [31:0]       pa_q, badva_q;
  logic [ASID_W-1:0] asid_q;
  logic [18:0]       vpn2_q, ctx_q;
  logic [1:0]        vpn2x_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= req_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      fault_q <= FLT_NONE;
      pa_q    <= '0;
      uc_q    <= 1'b0;
      badva_q <= '0;
      asid_q  <= '0;
      vpn2_q  <= '0;
      vpn2x_q <= '0;
      ctx_q   <= '0;
    end else if (req_valid) begin
      fault_q <= fault_d;
      pa_q    <= pa_d;
      uc_q    <= uc_d;
      badva_q <= badva_d;
      asid_q  <= asid_d;
      vpn2_q  <= vpn2_d;
      vpn2x_q <= vpn2x_d;
      ctx_q   <= vpn2_d;
    end
  end

  assign rsp_done     = done_q;
  assign rsp_fault    = 3'(fault_q);
  assign rsp_pa       = pa_q;
  assign rsp_uncached = uc_q;
  assign flt_badva    = badva_q;
  assign flt_asid     = asid_q;
  assign flt_vpn2     = vpn2_q;
  assign flt_vpn2x    = vpn2x_q;
  assign flt_ctx_vpn2 = ctx_q;

  // assertions
  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_q_n)
    req_valid |=> rsp_done); // R1
  AST_DONE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_q_n)
    rsp_done |-> $past(req_valid)); // R1
  AST_BYPASS_PA: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rsp_done && rsp_fault == 3'd0 && $past(req_va[31:30]) == 2'b10)
      |-> rsp_pa == {3'b000, $past(req_va[28:0])}); // R2
  AST_MOD_ONLY_STORE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rsp_done && rsp_fault == 3'd6) |-> $past(req_data && req_store)); // R8
  AST_BADVA_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rsp_done && rsp_fault != 3'd0) |-> flt_badva == $past(req_va)); // R10
  AST_UNCACHED_CLEAN: assert property (@(posedge clk) disable iff (!rst_q_n)
    rsp_uncached |-> rsp_fault == 3'd0); // R11
  AST_FAULT_PA_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rsp_fault != 3'd0) |-> rsp_pa == 32'd0); // R12
endmodule

// File: tb/sim_va_translator.sv
module sim_va_translator;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_kernel, req_misalign, req_data, req_store, small_pages;
  logic [31:0] req_va;
  logic [7:0]  req_asid;
  logic        tlb_hit, tlb_valid_even, tlb_valid_odd, tlb_dirty_even, tlb_dirty_odd;
  logic [4:0]  tlb_page_sh;
  logic [19:0] tlb_pfn_even, tlb_pfn_odd;
  logic [20:0] lk_vpn;
  logic [7:0]  lk_asid, flt_asid;
  logic        rsp_done, rsp_uncached;
  logic [31:0] rsp_pa, flt_badva;
  logic [2:0]  rsp_fault;
  logic [18:0] flt_vpn2, flt_ctx_vpn2;
  logic [1:0]  flt_vpn2x;

  always #4 clk = ~clk;

  va_translator u0 (.*);

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // expected state
  logic        e_done, e_uc;
  logic [31:0] e_pa, e_badva;
  logic [2:0]  e_fault;
  logic [7:0]  e_asid;
  logic [18:0] e_vpn2;
  logic [1:0]  e_vpn2x;
  string       e_tag;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [20:0] ref_vpn(logic [31:0] va, logic sp);
    int v = int'(va >> 11);
    if (!sp) v = v & ~3;
    return 21'(v);
  endfunction

  task automatic model();
    longint mask, base;
    logic [20:0] v;
    logic odd, hv, hd;
    e_pa = 0; e_uc = 0; e_fault = 0; e_badva = 0; e_asid = 0; e_vpn2 = 0; e_vpn2x = 0;
    v = ref_vpn(req_va, small_pages);
    if (req_va[31:30] == 2'b10) begin
      if (req_va[31:29] == 3'b100 && (!req_kernel || req_misalign)) begin
        e_fault = 1; e_tag = "R3";
      end else begin
        e_pa = req_va & 32'h1FFF_FFFF; e_tag = "R2";
      end
    end else if (req_misalign) begin
      e_fault = 1; e_tag = "R5";
    end else if (!tlb_hit) begin
      e_fault = req_data ? 3 : 2; e_tag = "R6";
    end else begin
      odd = req_va[tlb_page_sh];
      hv = odd ? tlb_valid_odd : tlb_valid_even;
      hd = odd ? tlb_dirty_odd : tlb_dirty_even;
      if (!hv) begin
        e_fault = req_data ? 5 : 4; e_tag = "R7";
      end else if (req_data && req_store && !hd) begin
        e_fault = 6; e_tag = "R8";
      end else begin
        mask = (longint'(1) << tlb_page_sh) - 1;
        base = longint'(odd ? tlb_pfn_odd : tlb_pfn_even) << 12;
        e_pa = 32'((base & ~mask) | (longint'(req_va) & mask));
        e_tag = "R9";
      end
    end
    if (e_fault != 0) e_badva = req_va;
    if (e_fault >= 2) begin
      e_asid = req_asid; e_vpn2 = v[20:2]; e_vpn2x = v[1:0];
    end
    e_uc = (e_fault == 0) && req_va[31] && req_va[29];
  endtask

  task automatic cycle();
    #1;
    if (req_valid) begin
      chk("R4 lk_vpn", 32'(lk_vpn), 32'(ref_vpn(req_va, small_pages)));
      chk("R4 lk_asid", 32'(lk_asid), 32'(req_asid));
      model();
    end
    e_done = req_valid;
    @(negedge clk);
    chk("R1 done", 32'(rsp_done), 32'(e_done));
    chk({e_tag, " fault"}, 32'(rsp_fault), 32'(e_fault));
    chk({e_tag, " R12 pa"}, rsp_pa, e_pa);
    chk("R11 uncached", 32'(rsp_uncached), 32'(e_uc));
    chk("R10 badva", flt_badva, e_badva);
    chk("R10 asid", 32'(flt_asid), 32'(e_asid));
    chk("R10 vpn2", 32'(flt_vpn2), 32'(e_vpn2));
    chk("R10 vpn2x", 32'(flt_vpn2x), 32'(e_vpn2x));
    chk("R10 ctx", 32'(flt_ctx_vpn2), 32'(e_vpn2));
  endtask

  task automatic req(logic [31:0] va, logic kern, logic mis, logic dat, logic st,
                     logic sp, logic hit, logic [4:0] sh, logic ve, logic vo,
                     logic de, logic dd);
    req_valid = 1; req_va = va; req_kernel = kern; req_misalign = mis;
    req_data = dat; req_store = st; small_pages = sp; tlb_hit = hit;
    tlb_page_sh = sh; tlb_valid_even = ve; tlb_valid_odd = vo;
    tlb_dirty_even = de; tlb_dirty_odd = dd;
    cycle();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      req_valid = 0; req_va = $urandom; tlb_hit = $urandom;
      cycle();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_va = 0; req_asid = 8'h5A; req_kernel = 0;
    req_misalign = 0; req_data = 0; req_store = 0; small_pages = 0; tlb_hit = 0;
    tlb_page_sh = 12; tlb_pfn_even = 20'h12345; tlb_pfn_odd = 20'hABCDE;
    tlb_valid_even = 0; tlb_valid_odd = 0; tlb_dirty_even = 0; tlb_dirty_odd = 0;
    e_done = 0; e_uc = 0; e_pa = 0; e_badva = 0; e_fault = 0; e_asid = 0;
    e_vpn2 = 0; e_vpn2x = 0; e_tag = "R13";
    repeat (3) @(negedge clk);
    cycle();                       // R13 reset state while held
    rst_n = 1;
    idle(3);
    // window bypass and privilege (R2, R3)
    req(32'h8123_4567, 1, 0, 1, 1, 0, 0, 12, 0, 0, 0, 0);
    req(32'h8123_4567, 0, 0, 0, 0, 0, 1, 12, 1, 1, 1, 1);
    req(32'h9FFF_FFFC, 1, 1, 1, 0, 0, 1, 12, 1, 1, 1, 1);
    req(32'hA765_4321, 0, 1, 1, 1, 0, 0, 12, 0, 0, 0, 0);
    idle(2);                       // R1 hold
    // mapped faults (R5, R6, R7)
    req(32'h0040_1000, 1, 1, 1, 0, 0, 1, 12, 1, 1, 1, 1);
    req(32'h0040_1000, 0, 0, 0, 0, 0, 0, 12, 1, 1, 1, 1);
    req(32'h7FFF_F800, 0, 0, 1, 0, 1, 0, 12, 1, 1, 1, 1);
    req(32'h0040_1000, 0, 0, 1, 0, 0, 1, 12, 1, 0, 1, 1);
    req(32'h0040_0000, 0, 0, 0, 0, 0, 1, 12, 0, 1, 1, 1);
    // dirty protection (R8)
    req(32'h0040_2010, 0, 0, 1, 1, 0, 1, 12, 1, 1, 0, 0);
    req(32'h0040_2010, 0, 0, 1, 0, 0, 1, 12, 1, 1, 0, 0);
    req(32'h0040_2010, 0, 0, 0, 1, 0, 1, 12, 1, 1, 0, 0);
    // page shifts and composition (R9), small pages (R4, R10)
    req(32'h0041_6ABC, 0, 0, 1, 0, 0, 1, 14, 1, 1, 1, 1);
    req(32'h0041_2ABC, 0, 0, 1, 0, 0, 1, 14, 1, 1, 1, 1);
    req(32'h1234_5C00, 0, 0, 1, 0, 1, 1, 10, 1, 1, 1, 1);
    req(32'h1234_5E00, 0, 0, 1, 0, 1, 0, 10, 1, 1, 1, 1);
    // high mapped region is uncached (R11)
    req(32'hE000_1234, 1, 0, 1, 0, 0, 1, 12, 1, 1, 1, 1);
    req(32'hC000_1234, 1, 0, 1, 0, 0, 1, 12, 1, 1, 1, 1);
    for (int i = 0; i < 3000; i++) begin
      req_asid = 8'($urandom); tlb_pfn_even = 20'($urandom); tlb_pfn_odd = 20'($urandom);
      req($urandom, 1'($urandom), 1'($urandom % 5 == 0), 1'($urandom), 1'($urandom),
          1'($urandom), 1'($urandom % 4 != 0), 5'(10 + 2 * ($urandom % 10)),
          1'($urandom % 4 != 0), 1'($urandom % 4 != 0), 1'($urandom), 1'($urandom));
      if ($urandom % 8 == 0) idle(1);
    end
    idle(2);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule